// File: doc/BRIEF.md
# Atomic Clock Divisor Register Bank

This block holds the loop parameters (feedback divisor M, reference divisor N and post divisor P) for three display clock synthesizers: clock 0, clock 2 and the LCD clock. Software programs them through a simple word-addressed write/read port with byte enables. A write to a divisor register only changes a staging copy. The parameter file that drives a synthesizer changes when the select byte for that clock is written. At that point the staged M and N and the newly written P move into the live file together, so the synthesizer never sees a half-programmed set.

The block also holds a miscellaneous-output register and an LCD control register. It combines them into a clock-source code for the downstream clock multiplexer. The LCD override bits take precedence over the miscellaneous-output field. For each clock, a one-cycle commit strobe marks the cycle in which new parameters become live.

Top module: `clk_div_regbank`

## Requirements
- R1: Word addresses 0, 1 and 2 are the divisor registers for clock 0, clock 2 and the LCD clock. Each places M in bits 9:0 and N in bits 25:16. Bits 31:26 and 15:10 read as 0 and ignore writes.
- R2: After reset every staged and live set holds M=0x13, N=0x03, P=0x00. A divisor read returns 0x00030013, `commit_o` is 0 and `clk_sel_o` is 0.
- R3: A divisor write changes only the staged copy. A read returns the staged value, and `m_o`, `n_o` and `p_o` stay unchanged.
- R4: A write to the select register (address 3) with byte enable k set copies slot k's staged M and N, together with data byte k as P, into slot k's live outputs. The new values are visible from the clock edge that takes the write.
- R5: Only slots whose select byte is enabled commit; the other slots keep their live values. Select byte 3 is reserved and reads 0. A select read returns the live P bytes.
- R6: `commit_o[k]` is high for exactly the one cycle in which slot k's new live values first appear, and it is low otherwise.
- R7: Byte enables apply to divisor writes. Byte 0 covers M[7:0], byte 1 covers M[9:8], byte 2 covers N[7:0] and byte 3 covers N[9:8].
- R8: Bits 3:2 of the misc-output register (address 4) pick the source. 00 gives `clk_sel_o`=0 (clock 0), 01 gives 1 (clock 1), and 1x gives 2 (clock 2).
- R9: When bits 31 and 0 of the LCD control register (address 5) are both 1, `clk_sel_o`=3 (LCD clock) and misc-output writes have no effect on it. If only one of the two bits is set, there is no override.
- R10: The misc-output register keeps bits 7:0 and reads 0 elsewhere. The LCD control register keeps only bits 31 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, taken at the rising edge |
| addr_i | input | 3 | Word address |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| m_o | output | 30 | Live M per slot, slot k at [10k +: 10] |
| n_o | output | 30 | Live N per slot, slot k at [10k +: 10] |
| p_o | output | 24 | Live P per slot, slot k at [8k +: 8] |
| commit_o | output | 3 | One-cycle commit strobe per slot |
| clk_sel_o | output | 2 | Active clock source code |

## Verification
Register reads are combinational, so the bench checks a read value after a short settle delay in the same cycle it sets the address. Live parameters, the commit strobes and the source code all change at the rising edge that takes the write. The bench drives each write on a falling edge, and it checks these results on the following falling edge, one edge after the write was taken. To confirm that the strobe lasts exactly one cycle, the bench checks it again one full cycle later and expects it to be low.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int DW    = 32;
  localparam int N_LSB = 16;

  typedef enum logic [1:0] {
    SRC_CLK0 = 2'd0,
    SRC_CLK1 = 2'd1,
    SRC_CLK2 = 2'd2,
    SRC_LCD  = 2'd3
  } clk_src_e;

  function automatic logic [DW-1:0] be_mask(input logic [DW/8-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = be[i/8];
    return m;
  endfunction
endpackage

// File: rtl/cdr_slot.sv
module cdr_slot
  import cdr_pkg::*;
#(
  parameter int M_W = 10,
  parameter int N_W = 10,
  parameter int P_W = 8,
  parameter logic [M_W-1:0] M_RST = M_W'(8'h13),
  parameter logic [N_W-1:0] N_RST = N_W'(8'h03),
  parameter logic [P_W-1:0] P_RST = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           div_we_i,
  input  logic [M_W-1:0] m_d_i,
  input  logic [M_W-1:0] m_msk_i,
  input  logic [N_W-1:0] n_d_i,
  input  logic [N_W-1:0] n_msk_i,
  input  logic           commit_i,
  input  logic [P_W-1:0] p_d_i,
  output logic [DW-1:0]  stg_word_o,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [P_W-1:0] p_o,
  output logic           strobe_o
);
  logic [M_W-1:0] stg_m;
  logic [N_W-1:0] stg_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_m <= M_RST;
      stg_n <= N_RST;
    end else if (div_we_i) begin
      stg_m <= (stg_m & ~m_msk_i) | (m_d_i & m_msk_i);
      stg_n <= (stg_n & ~n_msk_i) | (n_d_i & n_msk_i);
    end
  end

  // live file: whole set moves in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o      <= M_RST;
      n_o      <= N_RST;
      p_o      <= P_RST;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= commit_i;
      if (commit_i) begin
        m_o <= stg_m;
        n_o <= stg_n;
        p_o <= p_d_i;
      end
    end
  end

  always_comb begin
    stg_word_o                = '0;
    stg_word_o[M_W-1:0]       = stg_m;
    stg_word_o[N_LSB +: N_W]  = stg_n;
  end

  AST_LIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(m_o) && $stable(n_o) && $stable(p_o))); // R3

  AST_COMMIT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (m_o == $past(stg_m) && n_o == $past(stg_n) && p_o == $past(p_d_i))); // R4

  AST_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> strobe_o); // R6

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> !strobe_o); // R6
endmodule

// File: rtl/cdr_src_sel.sv
module cdr_src_sel
  import cdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       misc_we_i,
  input  logic [7:0] misc_d_i,
  input  logic       lcd_lo_we_i,
  input  logic       lcd_lo_d_i,
  input  logic       lcd_hi_we_i,
  input  logic       lcd_hi_d_i,
  output logic [7:0] misc_q_o,
  output logic       lcd_lo_q_o,
  output logic       lcd_hi_q_o,
  output clk_src_e   sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_q_o   <= '0;
      lcd_lo_q_o <= 1'b0;
      lcd_hi_q_o <= 1'b0;
    end else begin
      if (misc_we_i)   misc_q_o   <= misc_d_i;
      if (lcd_lo_we_i) lcd_lo_q_o <= lcd_lo_d_i;
      if (lcd_hi_we_i) lcd_hi_q_o <= lcd_hi_d_i;
    end
  end

  logic lcd_ovr;
  assign lcd_ovr = lcd_hi_q_o & lcd_lo_q_o;

  always_comb begin
    if (lcd_ovr)          sel_o = SRC_LCD;
    else if (misc_q_o[3]) sel_o = SRC_CLK2;
    else if (misc_q_o[2]) sel_o = SRC_CLK1;
    else                  sel_o = SRC_CLK0;
  end

  AST_LCD_MISC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_ovr && !lcd_lo_we_i && !lcd_hi_we_i) |=> $stable(sel_o)); // R9
endmodule

// File: rtl/clk_div_regbank.sv
module clk_div_regbank
  import cdr_pkg::*;
#(
  parameter int NUM_CLK = 3,
  parameter int ADDR_W  = 3,
  parameter int M_W     = 10,
  parameter int N_W     = 10,
  parameter int P_W     = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW/8-1:0]        be_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_CLK*M_W-1:0] m_o,
  output logic [NUM_CLK*N_W-1:0] n_o,
  output logic [NUM_CLK*P_W-1:0] p_o,
  output logic [NUM_CLK-1:0]     commit_o,
  output logic [1:0]             clk_sel_o
);
  localparam logic [ADDR_W-1:0] ADR_SEL  = ADDR_W'(NUM_CLK);
  localparam logic [ADDR_W-1:0] ADR_MISC = ADDR_W'(NUM_CLK + 1);
  localparam logic [ADDR_W-1:0] ADR_LCD  = ADDR_W'(NUM_CLK + 2);

  localparam logic [DW-1:0] DIV_USED =
    (DW'((64'd1 << M_W) - 1)) | (DW'((64'd1 << N_W) - 1) << N_LSB);

  logic [DW-1:0]      wmask;
  logic [DW-1:0]      stg_word [NUM_CLK];
  logic [NUM_CLK-1:0] commit_req;
  logic               sel_wr;
  logic [7:0]         misc_q;
  logic               lcd_lo_q, lcd_hi_q;
  clk_src_e           src;

  assign wmask  = be_mask(be_i);
  assign sel_wr = we_i && (addr_i == ADR_SEL);

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_slot
    logic div_we;
    assign div_we        = we_i && (addr_i == ADDR_W'(k));
    assign commit_req[k] = sel_wr && be_i[k];

    cdr_slot #(
      .M_W (M_W),
      .N_W (N_W),
      .P_W (P_W)
    ) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .div_we_i   (div_we),
      .m_d_i      (wdata_i[M_W-1:0]),
      .m_msk_i    (wmask[M_W-1:0]),
      .n_d_i      (wdata_i[N_LSB +: N_W]),
      .n_msk_i    (wmask[N_LSB +: N_W]),
      .commit_i   (commit_req[k]),
      .p_d_i      (wdata_i[8*k +: P_W]),
      .stg_word_o (stg_word[k]),
      .m_o        (m_o[k*M_W +: M_W]),
      .n_o        (n_o[k*N_W +: N_W]),
      .p_o        (p_o[k*P_W +: P_W]),
      .strobe_o   (commit_o[k])
    );
  end

  cdr_src_sel i_src_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .misc_we_i   (we_i && (addr_i == ADR_MISC) && be_i[0]),
    .misc_d_i    (wdata_i[7:0]),
    .lcd_lo_we_i (we_i && (addr_i == ADR_LCD) && be_i[0]),
    .lcd_lo_d_i  (wdata_i[0]),
    .lcd_hi_we_i (we_i && (addr_i == ADR_LCD) && be_i[DW/8-1]),
    .lcd_hi_d_i  (wdata_i[DW-1]),
    .misc_q_o    (misc_q),
    .lcd_lo_q_o  (lcd_lo_q),
    .lcd_hi_q_o  (lcd_hi_q),
    .sel_o       (src)
  );

  assign clk_sel_o = src;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CLK; k++) begin
      if (addr_i == ADDR_W'(k)) rdata_o = stg_word[k];
      if (addr_i == ADR_SEL)    rdata_o[8*k +: P_W] = p_o[k*P_W +: P_W];
    end
    if (addr_i == ADR_MISC) rdata_o[7:0] = misc_q;
    if (addr_i == ADR_LCD) begin
      rdata_o[0]    = lcd_lo_q;
      rdata_o[DW-1] = lcd_hi_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i & ~DIV_USED};

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < ADR_SEL) |-> ((rdata_o & ~DIV_USED) == '0)); // R1

  AST_ONE_SLOT_PER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> (commit_o == '0)); // R5
endmodule

// File: tb/test_clk_div_regbank.sv
module test_clk_div_regbank;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [29:0] m_o, n_o;
  logic [23:0] p_o;
  logic [2:0]  commit_o;
  logic [1:0]  clk_sel_o;

  int errors = 0;
  int checks = 0;

  clk_div_regbank i_clk_div_regbank (
    .clk_i, .rst_ni, .we_i, .addr_i, .be_i, .wdata_i,
    .rdata_o, .m_o, .n_o, .p_o, .commit_o, .clk_sel_o
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // drive on falling edge; returns at next falling edge, one edge after capture
  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; be_i = be; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic chk_live(input string req, input int k,
                          input logic [9:0] m, input logic [9:0] n, input logic [7:0] p);
    chk({req, " M"}, 32'(m_o[k*10 +: 10]), 32'(m));
    chk({req, " N"}, 32'(n_o[k*10 +: 10]), 32'(n));
    chk({req, " P"}, 32'(p_o[k*8 +: 8]), 32'(p));
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      rd("R2 div read", 3'(k), 32'h0003_0013);
      chk_live("R2 live", k, 10'h13, 10'h03, 8'h00);
    end
    chk("R2 commit", 32'(commit_o), 32'h0);
    chk("R2 sel", 32'(clk_sel_o), 32'h0);
  endtask

  task automatic t_stage();
    wr(3'd0, 4'hF, 32'hFFFF_FFFF);
    rd("R1 reserved", 3'd0, 32'h03FF_03FF);
    chk_live("R3 live held", 0, 10'h13, 10'h03, 8'h00);
    chk("R3 no strobe", 32'(commit_o), 32'h0);
  endtask

  task automatic t_commit();
    wr(3'd1, 4'hF, 32'h0123_0045);
    rd("R3 staged read", 3'd1, 32'h0123_0045);
    chk_live("R3 slot1 held", 1, 10'h13, 10'h03, 8'h00);
    wr(3'd3, 4'b0010, 32'h0000_5A00);
    chk_live("R4 slot1", 1, 10'h045, 10'h123, 8'h5A);
    chk("R6 strobe", 32'(commit_o), 32'h2);
    chk_live("R5 slot0 kept", 0, 10'h13, 10'h03, 8'h00);
    @(negedge clk_i);
    chk("R6 pulse end", 32'(commit_o), 32'h0);
  endtask

  task automatic t_bytes();
    wr(3'd2, 4'b0001, 32'hFFFF_FFAA);
    rd("R7 be0", 3'd2, 32'h0003_00AA);
    wr(3'd2, 4'b1000, 32'h0200_0000);
    rd("R7 be3", 3'd2, 32'h0203_00AA);
    wr(3'd3, 4'b1000, 32'hFF00_0000);
    chk("R5 rsvd lane no commit", 32'(commit_o), 32'h0);
    wr(3'd3, 4'b0100, 32'h0077_0000);
    chk_live("R4 slot2", 2, 10'h0AA, 10'h203, 8'h77);
    chk("R6 strobe2", 32'(commit_o), 32'h4);
  endtask

  task automatic t_multi();
    wr(3'd3, 4'b0111, 32'hEE33_2211);
    chk("R6 all strobes", 32'(commit_o), 32'h7);
    chk_live("R4 slot0", 0, 10'h3FF, 10'h3FF, 8'h11);
    chk_live("R4 slot1", 1, 10'h045, 10'h123, 8'h22);
    rd("R5 sel read", 3'd3, 32'h0033_2211);
  endtask

  task automatic t_misc();
    wr(3'd4, 4'h1, 32'h0000_0008);
    chk("R8 clk2", 32'(clk_sel_o), 32'h2);
    wr(3'd4, 4'h1, 32'h0000_0004);
    chk("R8 clk1", 32'(clk_sel_o), 32'h1);
    wr(3'd4, 4'h1, 32'h0000_000C);
    chk("R8 clk2 both", 32'(clk_sel_o), 32'h2);
    wr(3'd4, 4'h1, 32'h0000_0000);
    chk("R8 clk0", 32'(clk_sel_o), 32'h0);
    wr(3'd4, 4'hF, 32'hFFFF_FFF3);
    rd("R10 misc read", 3'd4, 32'h0000_00F3);
    chk("R8 bits1:0 no effect", 32'(clk_sel_o), 32'h0);
  endtask

  task automatic t_lcd();
    wr(3'd5, 4'hF, 32'h8000_0000);
    chk("R9 half override", 32'(clk_sel_o), 32'h0);
    wr(3'd5, 4'hF, 32'hFFFF_FFFF);
    chk("R9 override", 32'(clk_sel_o), 32'h3);
    rd("R10 lcd read", 3'd5, 32'h8000_0001);
    wr(3'd4, 4'h1, 32'h0000_0008);
    chk("R9 misc ignored", 32'(clk_sel_o), 32'h3);
    wr(3'd5, 4'h1, 32'h0000_0000);
    chk("R9 release", 32'(clk_sel_o), 32'h2);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_stage();
    t_commit();
    t_bytes();
    t_multi();
    t_misc();
    t_lcd();
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule